// File: doc/BRIEF.md
# Tiny Two-Register Stored-Program Core

This block is a very small 16-bit processor with separate instruction and data storage. It holds an address/immediate register, a data register and a program counter. Each clock cycle, while it is running, it executes one 16-bit word from a tiny instruction store. A word either loads an immediate into the address register or performs a computation. A computation can write its result to any mix of the address register, the data register and the data word, and it can branch on the sign of its result.

Data memory is reduced to one word. Every memory read or write goes to that word, whatever the address register holds, and its low bits drive the output pins. The instruction store has a power-of-two size. The program counter wraps at its end, so a program that fills the store repeats with no explicit branch.

An external loader fills the store through a write port while the `run` input is low. While `run` is low the core is held at address 0 and changes no register. Raising `run` starts execution from word 0. The register contents are kept across stops, so an initialisation program can be run first and a second program loaded after it.

Top module: `tcpu_core`

## Requirements
- R1: A word whose bit 15 is 0 loads bits 14:0 into the address register, with bit 15 of the register cleared, and the program counter advances by one.
- R2: A word whose bits 15:13 are all 1 is a compute word. Bit 12 selects the second operand: the address register when 0, the data word when 1. The first operand is always the data register. Bits 11:6 form the operation code. From bit 11 down to bit 6 its bits are: clear the first operand, invert the first operand, clear the second operand, invert the second operand, add (1) or AND (0), invert the output.
- R3: The operation code 000001 yields the bitwise XOR of the data register and the selected second operand. This replaces the inverted-AND that code would otherwise give.
- R4: In a compute word, bit 5 writes the result to the address register, bit 4 to the data register and bit 3 to the data word. These enables work independently in any combination, and all operands are the values held before the word executes.
- R5: In a compute word, bit 2 branches when the result is negative, bit 1 when it is zero and bit 0 when it is positive (signed, 16 bits). Any set condition that holds loads the program counter with the low bits of the address register as held before the word executes. All three bits set is an unconditional branch.
- R6: When no branch is taken, the program counter increments modulo the instruction store size (8 words by default), so execution wraps from the last word to word 0.
- R7: While `run` is low, the program counter is forced to 0 on every clock edge and the address register, data register and data word do not change.
- R8: The load port writes `ld_data` into word `ld_addr` on a clock edge with `ld_we` high only while `run` is low. While `run` is high, `ld_we` is ignored.
- R9: A word with bit 15 set but bits 15:13 not all 1 writes nothing and only advances the program counter.
- R10: Reset clears the registers, the data word and every instruction word. The output pins then read 0, and an all-zero word executes as a harmless load of 0 into the address register.
- R11: `out_pins` always equals the low 8 bits of the data word, and a compute word that reads the data word sees its full 16-bit value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | 1 executes instructions; 0 holds the core stopped at word 0 |
| ld_we | input | 1 | Write strobe for the instruction store (used only while stopped) |
| ld_addr | input | 3 | Instruction store word index for the load port |
| ld_data | input | 16 | Instruction word to store |
| out_pins | output | 8 | Low 8 bits of the data word |

## Verification
The data word is the only state visible at the ports. A wrong address register, data register or program counter therefore shows up only when a later compute word stores into the data word. The random programs set the data-word write enable on most compute words, so a corrupted register normally appears on `out_pins` within one or two instructions, and at the latest within one pass of the 8-word store. A branch to the wrong target or a broken wrap changes which word executes next. The bench compares the pins with its reference model after every clock edge, so such an error is reported in the cycle it first changes the output. Stop and load-port misbehaviour is caught when a program resumes at a word other than 0, or runs words that should never have been written.

// File: rtl/tcpu_pkg.sv
package tcpu_pkg;

    localparam int WORD_W = 16;
    localparam int IMM_W  = WORD_W - 1;
    localparam int OP_W   = 6;

    // operation code that selects XOR instead of the inverted AND
    localparam logic [OP_W-1:0] OP_XOR = 6'b000001;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        KIND_LOAD = 2'd0,
        KIND_CALC = 2'd1,
        KIND_NOP  = 2'd2
    } kind_e;

    typedef struct packed {
        kind_e            kind;
        logic             y_is_mem;
        logic [OP_W-1:0]  op;
        logic             to_a;
        logic             to_d;
        logic             to_m;
        logic             br_neg;
        logic             br_zero;
        logic             br_pos;
        logic [IMM_W-1:0] imm;
    } dec_t;

endpackage

// File: rtl/tcpu_imem.sv
module tcpu_imem #(
    parameter int WORDS = 8,
    parameter int AW    = $clog2(WORDS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [AW-1:0]           waddr,
    input  tcpu_pkg::word_t         wdata,
    input  logic [AW-1:0]           raddr,
    output tcpu_pkg::word_t         rdata
);
    import tcpu_pkg::*;

    word_t [WORDS-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (we) begin
            mem_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/tcpu_decode.sv
module tcpu_decode (
    input  tcpu_pkg::word_t instr,
    output tcpu_pkg::dec_t  dec
);
    import tcpu_pkg::*;

    always_comb begin
        dec          = '0;
        dec.imm      = instr[IMM_W-1:0];
        dec.y_is_mem = instr[12];
        dec.op       = instr[11:6];
        dec.to_a     = instr[5];
        dec.to_d     = instr[4];
        dec.to_m     = instr[3];
        dec.br_neg   = instr[2];
        dec.br_zero  = instr[1];
        dec.br_pos   = instr[0];
        if (!instr[WORD_W-1]) begin
            dec.kind = KIND_LOAD;
        end else if (instr[WORD_W-1:WORD_W-3] == 3'b111) begin
            dec.kind = KIND_CALC;
        end else begin
            dec.kind = KIND_NOP;
        end
    end

endmodule

// File: rtl/tcpu_alu.sv
module tcpu_alu (
    input  tcpu_pkg::word_t          x,
    input  tcpu_pkg::word_t          y,
    input  logic [tcpu_pkg::OP_W-1:0] op,
    output tcpu_pkg::word_t          res,
    output logic                     zero,
    output logic                     neg
);
    import tcpu_pkg::*;

    word_t x_z, x_n, y_z, y_n, core;

    always_comb begin
        x_z  = op[5] ? '0 : x;
        x_n  = op[4] ? ~x_z : x_z;
        y_z  = op[3] ? '0 : y;
        y_n  = op[2] ? ~y_z : y_z;
        core = op[1] ? (x_n + y_n) : (x_n & y_n);
        if (op == OP_XOR) begin
            res = x ^ y;
        end else begin
            res = op[0] ? ~core : core;
        end
        zero = (res == '0);
        neg  = res[WORD_W-1];
    end

endmodule

// File: rtl/tcpu_core.sv
module tcpu_core #(
    parameter int IMEM_WORDS = 8,
    parameter int OUT_W      = 8,
    parameter int AW         = $clog2(IMEM_WORDS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     run,
    input  logic                     ld_we,
    input  logic [AW-1:0]            ld_addr,
    input  logic [tcpu_pkg::WORD_W-1:0] ld_data,
    output logic [OUT_W-1:0]         out_pins
);
    import tcpu_pkg::*;

    typedef struct packed {
        logic [AW-1:0] pc;
        word_t         a;
        word_t         d;
        word_t         m;
    } state_t;

    state_t st_d, st_q;
    word_t  instr;
    dec_t   dec;
    word_t  y_op, res;
    logic   res_zero, res_neg, taken;
    logic [AW-1:0] pc_inc;

    // plain views of the state for the bound checker
    logic [AW-1:0] pc_q;
    word_t         a_q, d_q, m_q;
    assign pc_q = st_q.pc;
    assign a_q  = st_q.a;
    assign d_q  = st_q.d;
    assign m_q  = st_q.m;

    tcpu_imem #(.WORDS(IMEM_WORDS), .AW(AW)) u_imem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ld_we & ~run),
        .waddr (ld_addr),
        .wdata (ld_data),
        .raddr (st_q.pc),
        .rdata (instr)
    );

    tcpu_decode u_dec (
        .instr (instr),
        .dec   (dec)
    );

    assign y_op = dec.y_is_mem ? st_q.m : st_q.a;

    tcpu_alu u_alu (
        .x    (st_q.d),
        .y    (y_op),
        .op   (dec.op),
        .res  (res),
        .zero (res_zero),
        .neg  (res_neg)
    );

    always_comb begin
        st_d   = st_q;
        pc_inc = st_q.pc + 1'b1;
        taken  = (dec.br_neg  & res_neg)
               | (dec.br_zero & res_zero)
               | (dec.br_pos  & ~res_neg & ~res_zero);
        if (!run) begin
            st_d.pc = '0;
        end else begin
            unique case (dec.kind)
                KIND_LOAD: begin
                    st_d.a  = {1'b0, dec.imm};
                    st_d.pc = pc_inc;
                end
                KIND_CALC: begin
                    if (dec.to_a) st_d.a = res;
                    if (dec.to_d) st_d.d = res;
                    if (dec.to_m) st_d.m = res;
                    st_d.pc = taken ? st_q.a[AW-1:0] : pc_inc;
                end
                default: begin
                    st_d.pc = pc_inc;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_pins = st_q.m[OUT_W-1:0];

endmodule

// File: rtl/tcpu_core_chk.sv
module tcpu_core_chk #(
    parameter int AW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          run,
    input logic [15:0]   instr,
    input logic [AW-1:0] pc,
    input logic [15:0]   a,
    input logic [15:0]   d,
    input logic [15:0]   m
);

    AST_STOP_PC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (pc == '0)); // R7

    AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> ($stable(a) && $stable(d) && $stable(m))); // R7

    AST_IMM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !instr[15]) |=> (a == {1'b0, $past(instr[14:0])})); // R1

    AST_STEP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !instr[15]) |=> (pc == ($past(pc) + 1'b1))); // R6

    AST_BRANCH_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (run && instr[15:13] == 3'b111 && instr[2:0] == 3'b111)
        |=> (pc == $past(a[AW-1:0]))); // R5

    AST_NOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (run && instr[15] && instr[15:13] != 3'b111)
        |=> ($stable(a) && $stable(d) && $stable(m))); // R9

endmodule

bind tcpu_core tcpu_core_chk #(.AW(AW)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .instr (instr),
    .pc    (pc_q),
    .a     (a_q),
    .d     (d_q),
    .m     (m_q)
);

// File: tb/tcpu_core_tb.sv
module tcpu_core_tb;

    localparam int WORDS  = 8;
    localparam int AW     = 3;
    localparam int CLK_NS = 20;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          run;
    logic          ld_we;
    logic [AW-1:0] ld_addr;
    logic [15:0]   ld_data;
    logic [7:0]    out_pins;

    int checks = 0;
    int errors = 0;

    logic [15:0] ma, md, mm;
    logic [AW-1:0] mpc;
    logic [15:0] prog [WORDS];
    logic [15:0] img  [WORDS];

    tcpu_core u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .ld_we    (ld_we),
        .ld_addr  (ld_addr),
        .ld_data  (ld_data),
        .out_pins (out_pins)
    );

    always #(CLK_NS/2) clk = ~clk;

    function automatic logic [15:0] cw(input logic a, input logic [5:0] c,
                                       input logic [2:0] d, input logic [2:0] j);
        return {3'b111, a, c, d, j};
    endfunction

    function automatic logic [15:0] ref_alu(input logic [5:0] c,
                                            input logic [15:0] x, input logic [15:0] y);
        case (c)
            6'b101010: return 16'd0;
            6'b111111: return 16'd1;
            6'b111010: return 16'hFFFF;
            6'b001100: return x;
            6'b110000: return y;
            6'b001101: return ~x;
            6'b110001: return ~y;
            6'b001111: return -x;
            6'b110011: return -y;
            6'b011111: return x + 16'd1;
            6'b110111: return y + 16'd1;
            6'b001110: return x - 16'd1;
            6'b110010: return y - 16'd1;
            6'b000010: return x + y;
            6'b010011: return x - y;
            6'b000111: return y - x;
            6'b000000: return x & y;
            6'b010101: return x | y;
            6'b000001: return x ^ y;
            default:   return 16'hDEAD;
        endcase
    endfunction

    function automatic logic [5:0] pick_op(input int k);
        case (k)
            0: return 6'b101010;   1: return 6'b111111;   2: return 6'b111010;
            3: return 6'b001100;   4: return 6'b110000;   5: return 6'b001101;
            6: return 6'b110001;   7: return 6'b001111;   8: return 6'b110011;
            9: return 6'b011111;  10: return 6'b110111;  11: return 6'b001110;
           12: return 6'b110010;  13: return 6'b000010;  14: return 6'b010011;
           15: return 6'b000111;  16: return 6'b000000;  17: return 6'b010101;
           default: return 6'b000001;
        endcase
    endfunction

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic model_edge();
        logic [15:0] ins, y, r;
        logic tk;
        if (!rst_n) return;
        if (run) begin
            ins = prog[mpc];
            if (!ins[15]) begin
                ma  = {1'b0, ins[14:0]};
                mpc = mpc + 1'b1;
            end else if (ins[15:13] == 3'b111) begin
                y  = ins[12] ? mm : ma;
                r  = ref_alu(ins[11:6], md, y);
                tk = (ins[2] && r[15]) || (ins[1] && r == 16'd0)
                   || (ins[0] && !r[15] && r != 16'd0);
                mpc = tk ? ma[AW-1:0] : mpc + 1'b1;
                if (ins[5]) ma = r;
                if (ins[4]) md = r;
                if (ins[3]) mm = r;
            end else begin
                mpc = mpc + 1'b1;
            end
        end else begin
            mpc = '0;
            if (ld_we) prog[ld_addr] = ld_data;
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; run = 1'b0; ld_we = 1'b0; ld_addr = '0; ld_data = '0;
        tick(); tick();
        ma = '0; md = '0; mm = '0; mpc = '0;
        for (int i = 0; i < WORDS; i++) prog[i] = '0;
        rst_n = 1'b1;
    endtask

    task automatic load_img();
        run = 1'b0;
        for (int i = 0; i < WORDS; i++) begin
            ld_we = 1'b1; ld_addr = AW'(i); ld_data = img[i];
            tick();
        end
        ld_we = 1'b0;
    endtask

    task automatic run_cycles(input int n, input string tag);
        run = 1'b1;
        for (int i = 0; i < n; i++) begin
            tick();
            check(tag, {8'd0, out_pins}, {8'd0, mm[7:0]});
        end
        run = 1'b0;
    endtask

    task automatic clear_img();
        for (int i = 0; i < WORDS; i++) img[i] = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        @(negedge clk);
        do_reset();
        check("R10 reset output", {8'd0, out_pins}, 16'd0);

        // R10: all-zero store runs harmlessly
        run_cycles(10, "R10 zero words");
        check("R10 zero store output", {8'd0, out_pins}, 16'd0);

        // R6/R11 counter on word 0 only, wrap every 8 cycles; R8 load ignored while running
        clear_img();
        img[0] = cw(1'b1, 6'b110111, 3'b001, 3'b000);
        load_img();
        run = 1'b1; ld_we = 1'b1; ld_addr = '0; ld_data = 16'h0000;
        for (int i = 0; i < 16; i++) begin
            tick();
            check("R8 R6 counter", {8'd0, out_pins}, {8'd0, mm[7:0]});
        end
        ld_we = 1'b0; run = 1'b0;
        check("R6 wrap count", {8'd0, out_pins}, 16'd2);
        run_cycles(8, "R8 store unchanged");
        check("R8 store unchanged count", {8'd0, out_pins}, 16'd3);

        // R7: stopped core freezes, resumes at word 0
        for (int i = 0; i < 5; i++) begin
            tick();
            check("R7 frozen", {8'd0, out_pins}, 16'd3);
        end
        run_cycles(1, "R7 resume at word 0");
        check("R7 resume increments", {8'd0, out_pins}, 16'd4);

        // R1/R11 immediate to output
        do_reset();
        clear_img();
        img[0] = 16'h01A5;
        img[1] = cw(1'b0, 6'b110000, 3'b001, 3'b000);
        load_img();
        run_cycles(2, "R1 immediate");
        check("R1 R11 low byte", {8'd0, out_pins}, 16'h00A5);

        // R3 XOR
        clear_img();
        img[0] = 16'h005A;
        img[1] = cw(1'b0, 6'b001100 ^ 6'b111100, 3'b010, 3'b000); // D=A (110000)
        img[2] = 16'h000F;
        img[3] = cw(1'b0, 6'b000001, 3'b001, 3'b000);
        load_img();
        run_cycles(4, "R3 xor");
        check("R3 xor result", {8'd0, out_pins}, 16'h0055);

        // R4 multi-destination with pre-instruction operands
        clear_img();
        img[0] = 16'h0009;
        img[1] = cw(1'b0, 6'b110111, 3'b111, 3'b000);
        img[2] = cw(1'b1, 6'b000010, 3'b001, 3'b000);
        img[3] = cw(1'b0, 6'b110111, 3'b101, 3'b000);
        img[4] = cw(1'b0, 6'b110000, 3'b001, 3'b000);
        load_img();
        run_cycles(2, "R4 all dests");
        check("R4 all dests value", {8'd0, out_pins}, 16'd10);
        run_cycles(1, "R4 uses M");
        check("R2 R4 D+M", {8'd0, out_pins}, 16'd20);

        // R9 reserved words are no-ops
        clear_img();
        img[0] = 16'h0005;
        img[1] = cw(1'b0, 6'b110000, 3'b001, 3'b000);
        img[2] = 16'hC0FF;
        img[3] = 16'h9FF8;
        img[4] = cw(1'b0, 6'b110111, 3'b001, 3'b000);
        load_img();
        run_cycles(4, "R9 nop");
        check("R9 nop keeps output", {8'd0, out_pins}, 16'd5);
        run_cycles(1, "R9 nop keeps A");
        check("R9 nop A untouched", {8'd0, out_pins}, 16'd6);

        // R5 conditional and unconditional branches
        clear_img();
        img[0] = 16'h0007;
        img[1] = cw(1'b0, 6'b110000, 3'b010, 3'b000);
        img[2] = 16'h0005;
        img[3] = cw(1'b0, 6'b001100, 3'b000, 3'b001);
        img[4] = cw(1'b0, 6'b111010, 3'b001, 3'b000);
        img[5] = cw(1'b0, 6'b001100, 3'b001, 3'b000);
        img[6] = 16'h0000;
        img[7] = cw(1'b0, 6'b101010, 3'b000, 3'b111);
        load_img();
        run_cycles(6, "R5 branch");
        check("R5 branch skipped word", {8'd0, out_pins}, 16'd7);
        run_cycles(20, "R5 loop");
        check("R5 loop steady", {8'd0, out_pins}, 16'd7);

        // R2 random programs against the reference model
        for (int p = 0; p < 40; p++) begin
            for (int i = 0; i < WORDS; i++) begin
                int k;
                k = int'($urandom % 10);
                if (k < 3) begin
                    img[i] = {1'b0, 15'($urandom)};
                end else if (k == 3) begin
                    img[i] = {3'($urandom % 3) + 3'b100, 13'($urandom)};
                end else begin
                    img[i] = cw(1'($urandom), pick_op(int'($urandom % 19)),
                                3'($urandom) | 3'b001,
                                (($urandom % 4) == 0) ? 3'($urandom) : 3'b000);
                end
            end
            load_img();
            run_cycles(30, "R2 random program");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule